// File: doc/BRIEF.md
# Conflict-Aware Set Replacement Controller

This block decides which line of one set of a banked block store is replaced, and when lines should trade places. A set holds `NB` banks of `NW` lines each. Line `i` sits in bank `i % NB`, so the bank is the low bits of the line number. The block keeps a full age order over every line of the set. The front end uses it in three ways. It reports accesses, and each access says whether the line is the first line of its block. It asks for a victim when a new block is built, passing the bank mask of the block fetched just before. It reports bank conflicts seen during delivery.

A new block is steered away from the banks of the previous block whenever a line outside them exists. The chosen line then takes the oldest place in the age order, and the former oldest line takes the chosen line's old place, so the order stays consistent. Each block head carries a small saturating conflict counter. When a conflict brings that counter to a programmable threshold, the block issues one swap command. The command moves the conflicting line into a bank that is clear of the other block. The swap is allowed only if the partner line is older, or if the partner is itself a head line with conflicts of its own. Moving data and repairing pointers are left to the caller.

Top module: `xsr_set_repl`

## Requirements
- R1: After reset, line `i` holds age rank `i`, where 0 is youngest and N-1 is oldest. All head flags and conflict counters are zero, and both output valids are low.
- R2: An accepted access makes its line rank 0. Every line that was younger than it ages by one. No other line changes rank.
- R3: A new-block request reports `victim_vld` with `victim_line` one cycle later. The victim is the oldest line whose bank bit is clear in `new_prev_mask` (bit b = bank b). If every bank is masked, the victim is the oldest line.
- R4: On a request, the victim and the oldest line exchange ranks, so the victim becomes the oldest line.
- R5: An accepted access sets the line's head flag to `acc_head`. A conflict event on a line whose head flag is clear has no effect. A victim line loses its head flag, and its counter is cleared.
- R6: A conflict on a head line raises its 3-bit counter by one, saturating at 7. When the raised value is at least `thr`, a swap is issued, with `swap_vld` valid one cycle later.
- R7: A swap partner must lie in a bank other than the conflicting line's own bank, and its bit in `cf_mask` must be clear. It must also be older than the conflicting line, or be a head line with a nonzero counter. The oldest such line is taken. If no line qualifies, no swap is issued and the counter keeps its saturating value.
- R8: A swap reports `swap_src` (the conflicting line) and `swap_dst` (the partner). The two lines exchange ranks and head flags, and the moved block's counter is cleared at its new place.
- R9: At most one command is issued per cycle. A cycle that issues a swap drops that cycle's request and access: no victim is reported and ranks change only by the swap. A request also drops an access given in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr | input | CW | Conflict count that triggers a swap |
| acc_vld | input | 1 | Access event valid |
| acc_line | input | LW | Accessed line |
| acc_head | input | 1 | Accessed line is the first line of its block |
| new_req | input | 1 | New-block victim request |
| new_prev_mask | input | NB | Banks used by the previous block |
| cf_vld | input | 1 | Bank-conflict event valid |
| cf_line | input | LW | Head line of the block that conflicted |
| cf_mask | input | NB | Banks used by the block it conflicted with |
| victim_vld | output | 1 | Victim result valid |
| victim_line | output | LW | Line to be replaced |
| swap_vld | output | 1 | Swap command valid |
| swap_src | output | LW | Conflicting line to be moved |
| swap_dst | output | LW | Partner line it trades places with |

## Verification
A conflict that reaches the threshold can land in the same cycle as a new-block request or an access. The swap must then win, and the request and access must leave no trace. The bench provokes this by bringing a head line's counter to one below the threshold. It then drives the final conflict together with a request and an access in one cycle. It judges the result by the absence of a victim in the next cycle, and by the victims and swaps that later requests return, since these expose the age order. A randomized phase mixes all three event kinds against a reference model, so this collision and the request-over-access case recur many times.

// File: rtl/xsr_pkg.sv
package xsr_pkg;
  typedef enum logic [1:0] {
    RK_HOLD  = 2'd0,
    RK_TOUCH = 2'd1,
    RK_EXCH  = 2'd2
  } rk_op_e;
endpackage

// File: rtl/xsr_rank.sv
module xsr_rank
  import xsr_pkg::*;
#(
  parameter int N  = 8,
  parameter int RW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  rk_op_e          op,
  input  logic [RW-1:0]   a,
  input  logic [RW-1:0]   b,
  output logic [N*RW-1:0] rk_flat
);
  logic [RW-1:0] rk_q [N];
  logic [RW-1:0] rk_d [N];
  logic          upd;
  logic [N-1:0]  occ;

  assign upd = (op != RK_HOLD);

  always_comb begin
    for (int i = 0; i < N; i++) rk_d[i] = rk_q[i];
    unique case (op)
      RK_TOUCH: begin
        for (int i = 0; i < N; i++) begin
          if (RW'(i) == a)           rk_d[i] = '0;
          else if (rk_q[i] < rk_q[a]) rk_d[i] = rk_q[i] + RW'(1);
        end
      end
      RK_EXCH: begin
        rk_d[a] = rk_q[b];
        rk_d[b] = rk_q[a];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) rk_q[i] <= RW'(i);
    end else if (upd) begin
      for (int i = 0; i < N; i++) rk_q[i] <= rk_d[i];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    assign rk_flat[g*RW +: RW] = rk_q[g];
  end

  always_comb begin
    occ = '0;
    for (int i = 0; i < N; i++) occ[rk_q[i]] = 1'b1;
  end

  // R2: ranks always form a permutation
  p_rank_perm_r2: assert property (@(posedge clk) disable iff (!rst_n) &occ);
  // R2: a touched line becomes youngest
  p_touch_mru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op == RK_TOUCH |=> rk_q[$past(a)] == '0);
endmodule

// File: rtl/xsr_oldest.sv
module xsr_oldest #(
  parameter int N  = 8,
  parameter int RW = $clog2(N)
) (
  input  logic [N*RW-1:0] rk_flat,
  input  logic [N-1:0]    elig,
  output logic            found,
  output logic [RW-1:0]   id
);
  logic [RW-1:0] best_rk;

  always_comb begin
    found   = 1'b0;
    id      = '0;
    best_rk = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!found || rk_flat[i*RW +: RW] > best_rk)) begin
        found   = 1'b1;
        id      = RW'(i);
        best_rk = rk_flat[i*RW +: RW];
      end
    end
  end
endmodule

// File: rtl/xsr_conflict.sv
module xsr_conflict #(
  parameter int N  = 8,
  parameter int LW = $clog2(N),
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] thr,
  input  logic          cf_vld,
  input  logic [LW-1:0] cf_line,
  input  logic          acc_go,
  input  logic [LW-1:0] acc_line,
  input  logic          acc_head,
  input  logic          alloc_go,
  input  logic [LW-1:0] alloc_line,
  input  logic          swap_go,
  input  logic [LW-1:0] swap_dst,
  output logic          fire_cand,
  output logic [N-1:0]  gain
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q [N];
  logic [CW-1:0] cnt_d [N];
  logic [N-1:0]  head_q, head_d;
  logic [CW-1:0] cnt_inc;
  logic          cf_head, upd;

  assign cf_head   = cf_vld && head_q[cf_line];
  assign cnt_inc   = (cnt_q[cf_line] == CMAX) ? CMAX : cnt_q[cf_line] + CW'(1);
  assign fire_cand = cf_head && (cnt_inc >= thr);
  assign upd       = swap_go || cf_head || alloc_go || acc_go;

  for (genvar g = 0; g < N; g++) begin : g_gain
    assign gain[g] = head_q[g] && (cnt_q[g] != '0);
  end

  always_comb begin
    for (int i = 0; i < N; i++) cnt_d[i] = cnt_q[i];
    head_d = head_q;
    if (swap_go) begin
      cnt_d[cf_line]  = cnt_q[swap_dst];
      head_d[cf_line] = head_q[swap_dst];
      cnt_d[swap_dst]  = '0;
      head_d[swap_dst] = 1'b1;
    end else begin
      if (cf_head) cnt_d[cf_line] = cnt_inc;
      if (alloc_go) begin
        cnt_d[alloc_line]  = '0;
        head_d[alloc_line] = 1'b0;
      end else if (acc_go) begin
        head_d[acc_line] = acc_head;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) cnt_q[i] <= '0;
      head_q <= '0;
    end else if (upd) begin
      for (int i = 0; i < N; i++) cnt_q[i] <= cnt_d[i];
      head_q <= head_d;
    end
  end

  // R8: the moved block lands as a head with a cleared counter
  p_moved_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    swap_go |=> (cnt_q[$past(swap_dst)] == '0) && head_q[$past(swap_dst)]);
  // R5: conflicts on non-head lines leave the counter alone
  p_nonhead_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_vld && !head_q[cf_line] && !swap_go && !alloc_go)
      |=> cnt_q[$past(cf_line)] == $past(cnt_q[cf_line]));
endmodule

// File: rtl/xsr_set_repl.sv
module xsr_set_repl
  import xsr_pkg::*;
#(
  parameter int NB = 4,
  parameter int NW = 2,
  parameter int CW = 3,
  parameter int N  = NB * NW,
  parameter int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] thr,
  input  logic          acc_vld,
  input  logic [LW-1:0] acc_line,
  input  logic          acc_head,
  input  logic          new_req,
  input  logic [NB-1:0] new_prev_mask,
  input  logic          cf_vld,
  input  logic [LW-1:0] cf_line,
  input  logic [NB-1:0] cf_mask,
  output logic          victim_vld,
  output logic [LW-1:0] victim_line,
  output logic          swap_vld,
  output logic [LW-1:0] swap_src,
  output logic [LW-1:0] swap_dst
);
  localparam int BW = $clog2(NB);

  logic [N*LW-1:0] rk_flat;
  logic [LW-1:0]   rk_u [N];
  logic [N-1:0]    nc_elig, vic_elig, par_elig, gain;
  logic            vic_ok, lru_ok, par_ok, fire_cand;
  logic [LW-1:0]   vic_id, lru_id, par_id;
  logic            swap_go, alloc_go, acc_go;
  rk_op_e          rk_op;
  logic [LW-1:0]   rk_a, rk_b;

  for (genvar g = 0; g < N; g++) begin : g_line
    localparam logic [BW-1:0] BK = BW'(g);
    assign rk_u[g]     = rk_flat[g*LW +: LW];
    assign nc_elig[g]  = ~new_prev_mask[BK];
    assign par_elig[g] = (BK != cf_line[BW-1:0]) && !cf_mask[BK] &&
                         ((rk_u[g] > rk_u[cf_line]) || gain[g]);
  end

  assign vic_elig = (|nc_elig) ? nc_elig : '1;

  xsr_oldest #(.N(N), .RW(LW)) u_vic (
    .rk_flat(rk_flat), .elig(vic_elig), .found(vic_ok), .id(vic_id));
  xsr_oldest #(.N(N), .RW(LW)) u_lru (
    .rk_flat(rk_flat), .elig({N{1'b1}}), .found(lru_ok), .id(lru_id));
  xsr_oldest #(.N(N), .RW(LW)) u_par (
    .rk_flat(rk_flat), .elig(par_elig), .found(par_ok), .id(par_id));

  // Priority: swap, then new-block request, then access
  assign swap_go  = fire_cand && par_ok;
  assign alloc_go = new_req && !swap_go;
  assign acc_go   = acc_vld && !swap_go && !new_req;

  always_comb begin
    rk_op = RK_HOLD;
    rk_a  = acc_line;
    rk_b  = acc_line;
    if (swap_go) begin
      rk_op = RK_EXCH;
      rk_a  = cf_line;
      rk_b  = par_id;
    end else if (alloc_go) begin
      rk_op = RK_EXCH;
      rk_a  = vic_id;
      rk_b  = lru_id;
    end else if (acc_go) begin
      rk_op = RK_TOUCH;
    end
  end

  xsr_rank #(.N(N), .RW(LW)) u_rank (
    .clk(clk), .rst_n(rst_n), .op(rk_op), .a(rk_a), .b(rk_b), .rk_flat(rk_flat));

  xsr_conflict #(.N(N), .LW(LW), .CW(CW)) u_cf (
    .clk(clk), .rst_n(rst_n), .thr(thr),
    .cf_vld(cf_vld), .cf_line(cf_line),
    .acc_go(acc_go), .acc_line(acc_line), .acc_head(acc_head),
    .alloc_go(alloc_go), .alloc_line(vic_id),
    .swap_go(swap_go), .swap_dst(par_id),
    .fire_cand(fire_cand), .gain(gain));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      victim_vld <= 1'b0;
      swap_vld   <= 1'b0;
    end else begin
      victim_vld <= alloc_go;
      swap_vld   <= swap_go;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      victim_line <= '0;
    end else if (alloc_go) begin
      victim_line <= vic_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swap_src <= '0;
      swap_dst <= '0;
    end else if (swap_go) begin
      swap_src <= cf_line;
      swap_dst <= par_id;
    end
  end

  // R9: never a victim and a swap together
  p_one_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(swap_vld && victim_vld));
  // R4: the reported victim now holds the oldest rank
  p_victim_oldest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_go |=> rk_u[victim_line] == LW'(N-1));
  // R3: a free bank is always preferred
  p_victim_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_go && (|nc_elig)) |-> !new_prev_mask[vic_id[BW-1:0]]);
  // R7: partner bank is clear of both blocks
  p_swap_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    swap_go |-> (!cf_mask[par_id[BW-1:0]] && (par_id[BW-1:0] != cf_line[BW-1:0])));
  // R1: the lookup of the oldest line always succeeds
  p_lru_found_r1: assert property (@(posedge clk) disable iff (!rst_n) lru_ok && (vic_ok || !new_req));
endmodule

// File: tb/xsr_set_repl_tb.sv
`timescale 1ns/1ps
module xsr_set_repl_tb;
  localparam int NB = 4;
  localparam int N  = 8;
  localparam int LW = 3;
  localparam int CW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [CW-1:0] thr;
  logic          acc_vld, acc_head, new_req, cf_vld;
  logic [LW-1:0] acc_line, cf_line;
  logic [NB-1:0] new_prev_mask, cf_mask;
  logic          victim_vld, swap_vld;
  logic [LW-1:0] victim_line, swap_src, swap_dst;

  xsr_set_repl u_dut (
    .clk(clk), .rst_n(rst_n), .thr(thr),
    .acc_vld(acc_vld), .acc_line(acc_line), .acc_head(acc_head),
    .new_req(new_req), .new_prev_mask(new_prev_mask),
    .cf_vld(cf_vld), .cf_line(cf_line), .cf_mask(cf_mask),
    .victim_vld(victim_vld), .victim_line(victim_line),
    .swap_vld(swap_vld), .swap_src(swap_src), .swap_dst(swap_dst));

  typedef struct packed {
    logic          vv;
    logic [LW-1:0] vl;
    logic          sv;
    logic [LW-1:0] ss;
    logic [LW-1:0] sd;
  } exp_t;

  exp_t  exp_q [$];
  string tag_q [$];
  int    m_rk [N];
  bit    m_hd [N];
  int    m_cn [N];
  int    errors = 0;
  int    checks = 0;
  bit    done   = 1'b0;

  task automatic step(input bit av, input int al, input bit ah, input bit nr,
                      input int pm, input bit cv, input int cl, input int cm,
                      input string tag);
    exp_t e;
    int   par, v, lru, t, inc;
    bit   th, any;
    @(negedge clk);
    acc_vld = av; acc_line = LW'(al); acc_head = ah;
    new_req = nr; new_prev_mask = NB'(pm);
    cf_vld = cv; cf_line = LW'(cl); cf_mask = NB'(cm);
    e = '0;
    inc = (m_cn[cl] == 7) ? 7 : m_cn[cl] + 1;
    par = -1;
    if (cv && m_hd[cl] && inc >= int'(thr)) begin
      for (int p = 0; p < N; p++) begin
        if ((p % NB) != (cl % NB) && !cm[p % NB] &&
            (m_rk[p] > m_rk[cl] || (m_hd[p] && m_cn[p] != 0)))
          if (par < 0 || m_rk[p] > m_rk[par]) par = p;
      end
    end
    if (par >= 0) begin
      t = m_rk[cl]; m_rk[cl] = m_rk[par]; m_rk[par] = t;
      t = m_cn[par]; th = m_hd[par];
      m_cn[cl] = t; m_hd[cl] = th;
      m_cn[par] = 0; m_hd[par] = 1'b1;
      e.sv = 1'b1; e.ss = LW'(cl); e.sd = LW'(par);
    end else begin
      if (cv && m_hd[cl]) m_cn[cl] = inc;
      if (nr) begin
        any = 1'b0;
        for (int p = 0; p < N; p++) if (!pm[p % NB]) any = 1'b1;
        v = -1; lru = 0;
        for (int p = 0; p < N; p++) begin
          if (m_rk[p] == N - 1) lru = p;
          if (!any || !pm[p % NB])
            if (v < 0 || m_rk[p] > m_rk[v]) v = p;
        end
        t = m_rk[v]; m_rk[v] = m_rk[lru]; m_rk[lru] = t;
        m_hd[v] = 1'b0; m_cn[v] = 0;
        e.vv = 1'b1; e.vl = LW'(v);
      end else if (av) begin
        for (int p = 0; p < N; p++) if (m_rk[p] < m_rk[al]) m_rk[p]++;
        m_rk[al] = 0;
        m_hd[al] = ah;
      end
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic acc(input int l, input bit h, input string tag);
    step(1'b1, l, h, 1'b0, 0, 1'b0, 0, 0, tag);
  endtask
  task automatic req(input int m, input string tag);
    step(1'b0, 0, 1'b0, 1'b1, m, 1'b0, 0, 0, tag);
  endtask
  task automatic cf(input int l, input int m, input string tag);
    step(1'b0, 0, 1'b0, 1'b0, 0, 1'b1, l, m, tag);
  endtask
  task automatic idle(input string tag);
    step(1'b0, 0, 1'b0, 1'b0, 0, 1'b0, 0, 0, tag);
  endtask

  // Monitor: pop one expected item per cycle after the edge
  initial begin
    exp_t  e;
    string tg;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        checks++;
        if (victim_vld !== e.vv || (e.vv && victim_line !== e.vl) ||
            swap_vld !== e.sv || (e.sv && (swap_src !== e.ss || swap_dst !== e.sd))) begin
          errors++;
          $display("FAIL %s: got vic=%0b/%0d swap=%0b/%0d->%0d exp vic=%0b/%0d swap=%0b/%0d->%0d",
                   tg, victim_vld, victim_line, swap_vld, swap_src, swap_dst,
                   e.vv, e.vl, e.sv, e.ss, e.sd);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; thr = 3'd3;
    acc_vld = 0; acc_line = 0; acc_head = 0; new_req = 0; new_prev_mask = 0;
    cf_vld = 0; cf_line = 0; cf_mask = 0;
    for (int i = 0; i < N; i++) begin m_rk[i] = i; m_hd[i] = 0; m_cn[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (victim_vld !== 1'b0 || swap_vld !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got vic=%0b swap=%0b exp 0 0", victim_vld, swap_vld);
    end
    @(negedge clk);
    rst_n = 1'b1;

    req(0, "R1 oldest line after reset");
    req(4'b1000, "R3 avoid masked bank");
    req(0, "R4 victim became oldest");
    req(4'b1111, "R3 all banks masked");
    acc(6, 1'b0, "R2 touch");
    req(0, "R2 order after touch");

    // R5: non-head conflict ignored, head conflict counts
    thr = 3'd1;
    acc(1, 1'b1, "R5 mark head");
    cf(2, 0, "R5 conflict on non-head line");
    req(0, "R5 no change after ignored conflict");
    cf(1, 4'b0001, "R5 head conflict at threshold");
    req(0, "R8 ranks after swap");

    // R6: threshold of three
    thr = 3'd3;
    acc(3, 1'b1, "R6 mark head");
    cf(3, 0, "R6 first conflict");
    cf(3, 4'b0001, "R6 second conflict");
    cf(3, 4'b0001, "R6 third conflict swaps");
    cf(1, 0, "R8 moved block counter restarted");

    // R7: oldest head with no older partner and no gainers
    acc(5, 1'b1, "R7 mark head");
    for (int i = 0; i < N; i++) if (i != 5) acc(i, 1'b0, "R7 age others");
    thr = 3'd1;
    cf(5, 0, "R7 no eligible partner");
    cf(5, 0, "R7 counter saturates, still none");
    thr = 3'd7;
    acc(2, 1'b1, "R7 second head");
    cf(2, 4'b1111, "R7 gainer counts");
    thr = 3'd1;
    cf(5, 4'b1000, "R7 both gain swap");
    req(0, "R8 ranks after gain swap");

    // R9: swap collides with request and access
    thr = 3'd2;
    acc(4, 1'b1, "R9 mark head");
    cf(4, 0, "R9 count one");
    step(1'b1, 0, 1'b1, 1'b1, 0, 1'b1, 4, 0, "R9 swap wins");
    req(0, "R9 ranks untouched by dropped events");
    step(1'b1, 3, 1'b1, 1'b1, 4'b0010, 1'b0, 0, 0, "R9 request drops access");
    req(0, "R9 access left no trace");

    // Mixed random traffic
    for (int i = 0; i < 400; i++) begin
      if (i % 50 == 0) thr = CW'($urandom_range(0, 7));
      step(($urandom_range(0, 3) != 0), $urandom_range(0, N - 1), $urandom_range(0, 1),
           ($urandom_range(0, 4) == 0), $urandom_range(0, 15),
           ($urandom_range(0, 2) == 0), $urandom_range(0, N - 1), $urandom_range(0, 15),
           "R3 R6 R7 R9 mixed");
    end
    idle("R9 idle");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule